// File: doc/BRIEF.md
# Reduced Serial Test Access Port

This block is the serial test port of a memory device. A single test clock drives a sixteen-state controller that walks the standard boundary-scan state graph under the mode-select input. A three-bit instruction register then chooses which serial path sits between the data input and the data output. Only two data paths exist: a 32-bit identification register and a one-bit bypass stage. Every instruction other than the identification code selects bypass.

No dedicated test-reset pin is present. The controller is forced to its reset state by a power-on reset, or by holding mode-select high for five rising clock edges. In that state the instruction register falls back to the identification code, so a board-level scan chain can read the device identity without loading any instruction. Inputs are sampled on the rising clock edge. The serial output and its enable change only on the falling edge.

Top module: `tap_port`

## Requirements
- R1: While `por_n` is low the controller is held in Test-Logic-Reset, `tdo` and `tdo_en` are 0 and the active instruction is IDCODE (3'b001).
- R2: `tms` and `tdi` are sampled on the rising edge of `tck`, and the controller follows the sixteen-state graph, including the Pause and Exit2 detours, which leave a partly shifted register intact.
- R3: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. While `tms` stays high the port remains there with `tdo_en` low, and the active instruction is forced to IDCODE.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. Shift-IR moves it toward `tdo` LSB first with `tdi` entering the MSB, and the shifted value becomes the active instruction on the falling edge in Update-IR.
- R5: With IDCODE (3'b001) active, Capture-DR loads the 32-bit `ID_VALUE` (LSB = 1), which Shift-DR presents on `tdo` LSB first.
- R6: Any other instruction (3'b111 bypass, 3'b010 sample-z, and every undefined code) selects the bypass bit. It captures 0 and delays `tdi` by exactly one shift.
- R7: `tdo` changes only on the falling edge of `tck`.
- R8: `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR and is updated on the falling edge. `tdo` is 0 while `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | High while a register is being shifted out |

## Verification
The hardest case to reach from the pins is an interrupted data shift. The identification register must keep its partly shifted contents through Exit1, Pause and Exit2 and then resume at the next bit. The bench reads part of the ID, takes that detour, and checks that the remaining bits continue in sequence. Falling-edge timing is shown by sampling `tdo` just after a rising edge, where it must still hold the old bit, and again after the following falling edge. The five-high reset is driven from the middle of Shift-IR, after the instruction has been changed to bypass, so that the return to IDCODE can be seen in a following ID read.

// File: rtl/tap_port.sv
module tap_port #(
  parameter int IR_W = 3,
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5B_C0DF,
  parameter logic [IR_W-1:0] OP_IDCODE = 3'b001,
  parameter logic [IR_W-1:0] IR_CAPTURE = 3'b001
) (
  input  logic tck,
  input  logic por_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en
);

  typedef enum logic [3:0] {
    EXIT2_DR = 4'h0, EXIT1_DR = 4'h1, SHIFT_DR = 4'h2, PAUSE_DR = 4'h3,
    SEL_IR   = 4'h4, UPD_DR   = 4'h5, CAP_DR   = 4'h6, SEL_DR   = 4'h7,
    EXIT2_IR = 4'h8, EXIT1_IR = 4'h9, SHIFT_IR = 4'hA, PAUSE_IR = 4'hB,
    IDLE     = 4'hC, UPD_IR   = 4'hD, CAP_IR   = 4'hE, TLR      = 4'hF
  } tap_st_t;

  tap_st_t state, nxt;
  logic [IR_W-1:0] ir_shift, ir_reg;
  logic [ID_W-1:0] id_shift;
  logic            bypass;
  logic            sel_id;

  assign sel_id = (ir_reg == OP_IDCODE);

  always_comb begin
    case (state)
      TLR:      nxt = tms ? TLR      : IDLE;
      IDLE:     nxt = tms ? SEL_DR   : IDLE;
      SEL_DR:   nxt = tms ? SEL_IR   : CAP_DR;
      CAP_DR:   nxt = tms ? EXIT1_DR : SHIFT_DR;
      SHIFT_DR: nxt = tms ? EXIT1_DR : SHIFT_DR;
      EXIT1_DR: nxt = tms ? UPD_DR   : PAUSE_DR;
      PAUSE_DR: nxt = tms ? EXIT2_DR : PAUSE_DR;
      EXIT2_DR: nxt = tms ? UPD_DR   : SHIFT_DR;
      UPD_DR:   nxt = tms ? SEL_DR   : IDLE;
      SEL_IR:   nxt = tms ? TLR      : CAP_IR;
      CAP_IR:   nxt = tms ? EXIT1_IR : SHIFT_IR;
      SHIFT_IR: nxt = tms ? EXIT1_IR : SHIFT_IR;
      EXIT1_IR: nxt = tms ? UPD_IR   : PAUSE_IR;
      PAUSE_IR: nxt = tms ? EXIT2_IR : PAUSE_IR;
      EXIT2_IR: nxt = tms ? UPD_IR   : SHIFT_IR;
      UPD_IR:   nxt = tms ? SEL_DR   : IDLE;
      default:  nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= TLR;
    else        state <= nxt;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                ir_shift <= IR_CAPTURE;
    else if (state == CAP_IR)   ir_shift <= IR_CAPTURE;
    else if (state == SHIFT_IR) ir_shift <= {tdi, ir_shift[IR_W-1:1]};

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                          id_shift <= '0;
    else if (state == CAP_DR && sel_id)   id_shift <= ID_VALUE;
    else if (state == SHIFT_DR && sel_id) id_shift <= {tdi, id_shift[ID_W-1:1]};

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                bypass <= 1'b0;
    else if (state == CAP_DR)   bypass <= 1'b0;
    else if (state == SHIFT_DR) bypass <= tdi;

  always_ff @(negedge tck or negedge por_n)
    if (!por_n)              ir_reg <= OP_IDCODE;
    else if (state == TLR)    ir_reg <= OP_IDCODE;
    else if (state == UPD_IR) ir_reg <= ir_shift;

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == SHIFT_IR) || (state == SHIFT_DR);
      case (state)
        SHIFT_IR: tdo <= ir_shift[0];
        SHIFT_DR: tdo <= sel_id ? id_shift[0] : bypass;
        default:  tdo <= 1'b0;
      endcase
    end

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk #(
  parameter int IR_W = 3,
  parameter logic [IR_W-1:0] OP_IDCODE = 3'b001
) (
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input logic            tdi,
  input logic            tdo,
  input logic            tdo_en,
  input logic [3:0]      st,
  input logic [IR_W-1:0] ir,
  input logic [IR_W-1:0] ir_sh
);
  localparam logic [3:0] S_TLR = 4'hF, S_SDR = 4'h2, S_SIR = 4'hA, S_UIR = 4'hD;

  logic [2:0] ones;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n)      ones <= '0;
    else if (!tms)   ones <= '0;
    else if (ones != 3'd7) ones <= ones + 3'd1;

  // R3
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
    (ones >= 3'd5) |-> (st == S_TLR));

  // R3
  reset_loads_idcode_chk: assert property (@(posedge tck) disable iff (!por_n)
    ($past(st) == S_TLR) |-> (ir == OP_IDCODE));

  // R4
  update_ir_chk: assert property (@(posedge tck) disable iff (!por_n)
    ($past(st) == S_UIR) |-> (ir == $past(ir_sh)));

  // R8
  enable_in_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en == ((st == S_SIR) || (st == S_SDR)));

  // R8
  quiet_when_off_chk: assert property (@(posedge tck) disable iff (!por_n)
    !tdo_en |-> !tdo);

  // R6
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!por_n)
    ($past(st) == S_SDR && st == S_SDR && ir != OP_IDCODE) |-> (tdo == $past(tdi)));

endmodule

bind tap_port tap_port_chk #(.IR_W(IR_W), .OP_IDCODE(OP_IDCODE)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
  .st(state), .ir(ir_reg), .ir_sh(ir_shift)
);

// File: tb/tap_port_bench.sv
module tap_port_bench;
  localparam logic [31:0] ID = 32'h1A5B_C0DF;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic tdo, tdo_en;
  int vecs = 0, bad = 0;
  bit done = 0;

  tap_port u_tap_port (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
                       .tdo(tdo), .tdo_en(tdo_en));

  always #5 tck = ~tck;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  // from Run-Test/Idle: read the full ID, optionally pausing after bit 11
  task automatic scan_id(input string tag, input bit detour);
    logic [31:0] got;
    step(1, 1); step(0, 1); step(0, 1);
    chk({tag, " R8 enable in Shift-DR"}, {31'b0, tdo_en}, 1);
    got[0] = tdo;
    for (int i = 1; i < 32; i++) begin
      if (detour && i == 12) begin
        step(1, 1);
        chk({tag, " R8 enable off in Exit1"}, {31'b0, tdo_en}, 0);
        step(0, 1); step(1, 1); step(0, 1);
      end else step(0, 1);
      got[i] = tdo;
    end
    chk({tag, " R5 ID value"}, got, ID);
    step(1, 1); step(1, 1); step(0, 1);
  endtask

  task automatic load_ir(input logic [2:0] code);
    logic [2:0] cap;
    step(1, 1); step(1, 1); step(0, 1); step(0, 1);
    cap[0] = tdo;
    step(0, code[0]); cap[1] = tdo;
    step(0, code[1]); cap[2] = tdo;
    step(1, code[2]);
    chk("R4 Capture-IR pattern", {29'b0, cap}, 32'd1);
    step(1, 1); step(0, 1);
  endtask

  task automatic scan_bypass(input string tag, input logic [7:0] p);
    step(1, 1); step(0, 1); step(0, 1);
    chk({tag, " R6 bypass captures 0"}, {31'b0, tdo}, 0);
    for (int i = 0; i < 8; i++) begin
      step(0, p[i]);
      chk({tag, " R6 one-stage delay"}, {31'b0, tdo}, {31'b0, p[i]});
    end
    step(1, 1); step(1, 1); step(0, 1);
  endtask

  task automatic t_reset();
    @(negedge tck); #1;
    chk("R1 tdo in reset", {31'b0, tdo}, 0);
    chk("R1 tdo_en in reset", {31'b0, tdo_en}, 0);
    por_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1, 1);
      chk("R3 idle high tms keeps enable off", {31'b0, tdo_en}, 0);
    end
    step(0, 1);
    scan_id("R1 default IDCODE", 0);
  endtask

  task automatic t_bypass();
    load_ir(3'b111);
    scan_bypass("code 111", 8'b1011_0010);
  endtask

  task automatic t_other_codes();
    load_ir(3'b010);
    scan_bypass("code 010", 8'b0110_1001);
    load_ir(3'b101);
    scan_bypass("code 101", 8'b1100_0111);
    load_ir(3'b001);
    scan_id("R4 IDCODE reloaded", 0);
  endtask

  task automatic t_pause();
    scan_id("R2 pause detour", 1);
  endtask

  task automatic t_edge();
    load_ir(3'b111);
    step(1, 1); step(0, 1); step(0, 1);
    tms = 1'b0; tdi = 1'b1;
    @(posedge tck); #1;
    chk("R7 tdo holds after rising edge", {31'b0, tdo}, 0);
    @(negedge tck); #1;
    chk("R7 tdo moves on falling edge", {31'b0, tdo}, 1);
    step(1, 1); step(1, 1); step(0, 1);
  endtask

  task automatic t_five_high();
    load_ir(3'b111);
    step(1, 1); step(1, 1); step(0, 1); step(0, 0);
    chk("R8 enable in Shift-IR", {31'b0, tdo_en}, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R3 enable off after five highs", {31'b0, tdo_en}, 0);
    step(0, 1);
    scan_id("R3 five highs restore IDCODE", 0);
  endtask

  task automatic t_por_mid();
    load_ir(3'b111);
    step(1, 1); step(0, 1); step(0, 1);
    #2 por_n = 1'b0; #1;
    chk("R1 por clears enable", {31'b0, tdo_en}, 0);
    @(negedge tck); #1 por_n = 1'b1;
    step(0, 1);
    scan_id("R1 por restores IDCODE", 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_other_codes();
    t_pause();
    t_edge();
    t_five_high();
    t_por_mid();
    finish_run();
  end

  initial begin
    #500000;
    vecs++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule